// File: doc/BRIEF.md
# Receive Descriptor Writeback Formatter

This block assembles the 128-bit completion descriptor that a receive path hands back to the host once a frame sits in its buffer. The parser has already worked out the frame length, whether the frame is IPv4, TCP or UDP, the raw IP and L4 checksum results and the IP identification. The formatter combines these with a few configuration bits and emits the descriptor in one of two layouts. A three-bit layout selector picks the layout. The older compact layout carries 8-bit status and error bytes. The newer single-buffer layout carries a packet-type field, a 20-bit status word, a 12-bit error word and an identification/checksum word that can be zeroed.

Before it emits anything, the block works out how large the receive buffer was and rejects frames that would not have fit. It also rejects layout codes it does not implement. In both cases it pulses an error output for one cycle and writes no descriptor. Hash, VLAN and header-split fields are always written as zero. The result appears one clock after the input strobe.

Top module: `rx_wb_formatter`

## Requirements
- R1: `cfg_desc_type` 3'b000 selects the compact layout and 3'b001 selects the single-buffer layout. Any other code produces a one-cycle `out_err_type` pulse and no `out_valid`.
- R2: Status always has DD (0x001) and EOP (0x002) set. For an IPv4 frame, IPCS (0x040) is added when `cfg_ip_chk` is set. TCPCS (0x020) is added for TCP and UDPCS (0x010) for UDP when `cfg_l4_chk` is set. A non-IPv4 frame gets only DD|EOP, packet type 0 and checksum 0. Compact status is desc[103:96]; single-buffer status is desc[83:64].
- R3: Compact error byte desc[111:104] has 0x40 when the IP checksum is checked and `ip_csum` is nonzero. It has 0x20 when the L4 checksum is checked and `l4_csum` is nonzero, for both TCP and UDP.
- R4: Single-buffer error field desc[95:84] uses 0x800 for a bad IP checksum and 0x400 for a bad TCP or UDP checksum, under the same conditions as R3.
- R5: Single-buffer packet type desc[15:4] has 0x001 for every IPv4 frame. It adds 0x010 for TCP and 0x020 for UDP when `cfg_l4_chk` is set.
- R6: The written length is `frame_len` + 4, modulo 2^16, unless `cfg_strip_crc` is set, in which case it is `frame_len`. It goes to desc[79:64] in the compact layout and desc[111:96] in the single-buffer layout.
- R7: The reported checksum is `l4_csum` when the L4 checksum is checked. Otherwise it is `ip_csum` when the IP checksum is checked, and otherwise 0. In the compact layout it is at desc[95:80].
- R8: In the single-buffer layout, desc[63:32] is zero when `cfg_no_ident` is set. Otherwise `ip_ident` is at desc[47:32] and the checksum at desc[63:48].
- R9: The buffer length is `cfg_buf_kb`×1024 when the single-buffer layout is used with `cfg_long_pkt` set. In every other case it is `cfg_legacy_buf`. If `frame_len` ≥ buffer length, the block pulses `out_err_len` and writes no descriptor.
- R10: Zero fields: compact desc[63:0] and desc[127:112]. Single-buffer desc[3:0], desc[31:16] and desc[127:112].
- R11: Results appear on the cycle after `in_valid` and last exactly one cycle. Reset (synchronous, active low) clears all outputs. `out_desc` is zero whenever `out_valid` is low.
- R12: At most one of `out_valid`, `out_err_len` and `out_err_type` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One stored frame is ready to complete |
| frame_len | input | 16 | Frame length in bytes |
| is_ipv4 | input | 1 | Frame is IPv4 |
| is_tcp | input | 1 | Frame carries TCP |
| is_udp | input | 1 | Frame carries UDP |
| ip_csum | input | 16 | IP header checksum result; nonzero means bad |
| l4_csum | input | 16 | TCP/UDP checksum result; nonzero means bad |
| ip_ident | input | 16 | IP identification |
| cfg_desc_type | input | 3 | Layout selector |
| cfg_ip_chk | input | 1 | Enable IP checksum reporting |
| cfg_l4_chk | input | 1 | Enable TCP/UDP checksum reporting |
| cfg_no_ident | input | 1 | Zero the identification/checksum word |
| cfg_strip_crc | input | 1 | CRC already stripped, no +4 |
| cfg_long_pkt | input | 1 | Use the KB buffer size field |
| cfg_buf_kb | input | PKTF_W | Buffer size in KB for long-packet mode |
| cfg_legacy_buf | input | 16 | Default buffer size in bytes |
| out_valid | output | 1 | Descriptor valid, one cycle |
| out_desc | output | 128 | Completion descriptor |
| out_err_len | output | 1 | Frame did not fit the buffer |
| out_err_type | output | 1 | Unsupported layout code |

## Verification
The assertions check the following on every cycle:
- the three outputs are mutually exclusive;
- every result follows an input strobe by exactly one cycle;
- an error pulse for the layout code only follows an unsupported code;
- DD and EOP sit at the right place for the chosen layout;
- the length field matches the frame length and strip setting seen one cycle earlier;
- VLAN bits stay zero.

The bench's scenarios show the rest:
- the combinations of offload enables, frame class and checksum outcomes;
- checksum selection priority;
- zeroing of the identification word;
- the exact buffer-length boundary in each sizing mode.

// File: rtl/rx_wb_pkg.sv
// Shared constants and types for the receive writeback formatter.
// Assumes descriptor length/checksum/ident fields are 16 bits wide.
package rx_wb_pkg;
    localparam int FIELD_W = 16;
    localparam int DESC_W  = 128;

    localparam logic [2:0] DT_COMPACT = 3'b000;
    localparam logic [2:0] DT_ONEBUF  = 3'b001;

    localparam logic [FIELD_W-1:0] CRC_BYTES = 16'd4;

    // compact layout codes
    localparam logic [7:0]  CST_DD    = 8'h01;
    localparam logic [7:0]  CST_EOP   = 8'h02;
    localparam logic [7:0]  CST_UDPCS = 8'h10;
    localparam logic [7:0]  CST_TCPCS = 8'h20;
    localparam logic [7:0]  CST_IPCS  = 8'h40;
    localparam logic [7:0]  CER_L4    = 8'h20;
    localparam logic [7:0]  CER_IP    = 8'h40;

    // single-buffer layout codes
    localparam logic [11:0] AER_L4    = 12'h400;
    localparam logic [11:0] AER_IP    = 12'h800;
    localparam logic [11:0] APT_IPV4  = 12'h001;
    localparam logic [11:0] APT_TCP   = 12'h010;
    localparam logic [11:0] APT_UDP   = 12'h020;

    // layout-neutral classification result
    typedef struct packed {
        logic ip_cs;
        logic tcp_cs;
        logic udp_cs;
        logic ip_err;
        logic l4_err;
        logic is_v4;
    } rx_flags_t;
endpackage

// File: rtl/rx_wb_buflen.sv
// Works out the receive buffer size and flags frames that do not fit.
// Assumes the KB field scaled by 2^KB_SHIFT fits in BUF_W bits.
module rx_wb_buflen #(
    parameter int PKTF_W   = 7,
    parameter int KB_SHIFT = 10
) (
    input  logic                          onebuf,
    input  logic                          long_pkt,
    input  logic [PKTF_W-1:0]             buf_kb,
    input  logic [rx_wb_pkg::FIELD_W-1:0] legacy_buf,
    input  logic [rx_wb_pkg::FIELD_W-1:0] frame_len,
    output logic                          too_long
);
    localparam int SCALED_W = PKTF_W + KB_SHIFT;
    localparam int BUF_W = (SCALED_W > rx_wb_pkg::FIELD_W) ? SCALED_W : rx_wb_pkg::FIELD_W;

    logic [BUF_W-1:0] buf_bytes;

    // pick KB-scaled size only for single-buffer long-packet mode
    always_comb begin
        if (onebuf && long_pkt)
            buf_bytes = BUF_W'(buf_kb) << KB_SHIFT;
        else
            buf_bytes = BUF_W'(legacy_buf);
        too_long = BUF_W'(frame_len) >= buf_bytes;
    end
endmodule

// File: rtl/rx_wb_classify.sv
// Turns parser results and offload enables into layout-neutral flags
// and selects the checksum to report. L4 results count only for IPv4.
module rx_wb_classify
    import rx_wb_pkg::*;
(
    input  logic               is_ipv4,
    input  logic               is_tcp,
    input  logic               is_udp,
    input  logic               ip_chk,
    input  logic               l4_chk,
    input  logic [FIELD_W-1:0] ip_csum,
    input  logic [FIELD_W-1:0] l4_csum,
    output rx_flags_t          flags,
    output logic [FIELD_W-1:0] csum_sel
);
    logic ip_checked;
    logic l4_checked;

    // derive which checks ran, their outcome and the reported checksum
    always_comb begin
        ip_checked     = is_ipv4 && ip_chk;
        l4_checked     = is_ipv4 && l4_chk && (is_tcp || is_udp);
        flags.is_v4    = is_ipv4;
        flags.ip_cs    = ip_checked;
        flags.tcp_cs   = is_ipv4 && l4_chk && is_tcp;
        flags.udp_cs   = is_ipv4 && l4_chk && is_udp;
        flags.ip_err   = ip_checked && (ip_csum != '0);
        flags.l4_err   = l4_checked && (l4_csum != '0);
        if (l4_checked)
            csum_sel = l4_csum;
        else if (ip_checked)
            csum_sel = ip_csum;
        else
            csum_sel = '0;
    end
endmodule

// File: rtl/rx_wb_pack.sv
// Encodes classified flags into the compact or single-buffer descriptor.
// Unused fields (hash type, header length, VLAN) are driven to zero.
module rx_wb_pack
    import rx_wb_pkg::*;
(
    input  logic               onebuf,
    input  rx_flags_t          flags,
    input  logic [FIELD_W-1:0] wr_len,
    input  logic [FIELD_W-1:0] csum,
    input  logic [FIELD_W-1:0] ident,
    input  logic               no_ident,
    output logic [DESC_W-1:0]  desc
);
    logic [7:0]  c_stat;
    logic [7:0]  c_err;
    logic [19:0] a_stat;
    logic [11:0] a_err;
    logic [11:0] a_ptype;
    logic [31:0] a_word;

    // build per-layout status, error and packet-type codes
    always_comb begin
        c_stat = CST_DD | CST_EOP
               | (flags.ip_cs  ? CST_IPCS  : 8'h00)
               | (flags.tcp_cs ? CST_TCPCS : 8'h00)
               | (flags.udp_cs ? CST_UDPCS : 8'h00);
        c_err  = (flags.ip_err ? CER_IP : 8'h00) | (flags.l4_err ? CER_L4 : 8'h00);
        a_stat = {12'h000, c_stat};
        a_err  = (flags.ip_err ? AER_IP : 12'h000) | (flags.l4_err ? AER_L4 : 12'h000);
        a_ptype = (flags.is_v4  ? APT_IPV4 : 12'h000)
                | (flags.tcp_cs ? APT_TCP  : 12'h000)
                | (flags.udp_cs ? APT_UDP  : 12'h000);
        a_word = no_ident ? 32'h0 : {csum, ident};
    end

    // assemble the selected layout
    always_comb begin
        if (onebuf)
            desc = {16'h0000, wr_len, a_err, a_stat, a_word, 16'h0000, a_ptype, 4'h0};
        else
            desc = {16'h0000, c_err, c_stat, csum, wr_len, 64'h0};
    end
endmodule

// File: rtl/rx_wb_formatter.sv
// Top of the receive writeback formatter: checks layout code and buffer
// fit, builds the descriptor and registers one result per input strobe.
// Assumes configuration is stable while in_valid is high.
module rx_wb_formatter
    import rx_wb_pkg::*;
#(
    parameter int PKTF_W   = 7,
    parameter int KB_SHIFT = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [15:0]        frame_len,
    input  logic               is_ipv4,
    input  logic               is_tcp,
    input  logic               is_udp,
    input  logic [15:0]        ip_csum,
    input  logic [15:0]        l4_csum,
    input  logic [15:0]        ip_ident,
    input  logic [2:0]         cfg_desc_type,
    input  logic               cfg_ip_chk,
    input  logic               cfg_l4_chk,
    input  logic               cfg_no_ident,
    input  logic               cfg_strip_crc,
    input  logic               cfg_long_pkt,
    input  logic [PKTF_W-1:0]  cfg_buf_kb,
    input  logic [15:0]        cfg_legacy_buf,
    output logic               out_valid,
    output logic [127:0]       out_desc,
    output logic               out_err_len,
    output logic               out_err_type
);
    logic               onebuf;
    logic               type_ok;
    logic               too_long;
    logic [FIELD_W-1:0] wr_len;
    logic [FIELD_W-1:0] csum_sel;
    rx_flags_t          flags;
    logic [DESC_W-1:0]  desc_c;

    // decode layout code and compute written length
    always_comb begin
        onebuf  = (cfg_desc_type == DT_ONEBUF);
        type_ok = (cfg_desc_type == DT_COMPACT) || onebuf;
        wr_len  = frame_len + (cfg_strip_crc ? '0 : CRC_BYTES);
    end

    rx_wb_buflen #(.PKTF_W(PKTF_W), .KB_SHIFT(KB_SHIFT)) u_buflen (
        .onebuf     (onebuf),
        .long_pkt   (cfg_long_pkt),
        .buf_kb     (cfg_buf_kb),
        .legacy_buf (cfg_legacy_buf),
        .frame_len  (frame_len),
        .too_long   (too_long)
    );

    rx_wb_classify u_classify (
        .is_ipv4  (is_ipv4),
        .is_tcp   (is_tcp),
        .is_udp   (is_udp),
        .ip_chk   (cfg_ip_chk),
        .l4_chk   (cfg_l4_chk),
        .ip_csum  (ip_csum),
        .l4_csum  (l4_csum),
        .flags    (flags),
        .csum_sel (csum_sel)
    );

    rx_wb_pack u_pack (
        .onebuf   (onebuf),
        .flags    (flags),
        .wr_len   (wr_len),
        .csum     (csum_sel),
        .ident    (ip_ident),
        .no_ident (cfg_no_ident),
        .desc     (desc_c)
    );

    // register one outcome per strobe; errors suppress the descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_desc     <= '0;
            out_err_len  <= 1'b0;
            out_err_type <= 1'b0;
        end else begin
            out_valid    <= in_valid && type_ok && !too_long;
            out_err_type <= in_valid && !type_ok;
            out_err_len  <= in_valid && type_ok && too_long;
            out_desc     <= (in_valid && type_ok && !too_long) ? desc_c : '0;
        end
    end
endmodule

// File: rtl/rx_wb_formatter_chk.sv
// Cycle-level properties of the writeback formatter, bound to its top.
// Assumes synchronous active-low reset on rst_n.
module rx_wb_formatter_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [15:0]  frame_len,
    input logic [2:0]   cfg_desc_type,
    input logic         cfg_strip_crc,
    input logic         out_valid,
    input logic [127:0] out_desc,
    input logic         out_err_len,
    input logic         out_err_type
);
    assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_err_len, out_err_type}));

    assert_follows_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_err_len || out_err_type) |-> $past(in_valid));

    assert_desc_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_desc == 128'h0));

    assert_bad_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_err_type |-> ($past(cfg_desc_type) != 3'b000 && $past(cfg_desc_type) != 3'b001));

    assert_compact_ddeop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_desc_type) == 3'b000) |-> (out_desc[97:96] == 2'b11));

    assert_onebuf_ddeop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_desc_type) == 3'b001) |-> (out_desc[65:64] == 2'b11));

    assert_compact_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_desc_type) == 3'b000) |->
        (out_desc[79:64] == 16'($past(frame_len) + ($past(cfg_strip_crc) ? 16'd0 : 16'd4))));

    assert_onebuf_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_desc_type) == 3'b001) |->
        (out_desc[111:96] == 16'($past(frame_len) + ($past(cfg_strip_crc) ? 16'd0 : 16'd4))));

    assert_vlan_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_desc[127:112] == 16'h0));
endmodule

bind rx_wb_formatter rx_wb_formatter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .frame_len     (frame_len),
    .cfg_desc_type (cfg_desc_type),
    .cfg_strip_crc (cfg_strip_crc),
    .out_valid     (out_valid),
    .out_desc      (out_desc),
    .out_err_len   (out_err_len),
    .out_err_type  (out_err_type)
);

// File: tb/rx_wb_formatter_tb.sv
// Sweeps layout code, frame class, offload enables, checksum outcomes,
// strip and ident settings, then probes buffer-length boundaries.
module rx_wb_formatter_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [15:0]  frame_len = '0;
    logic         is_ipv4 = 1'b0, is_tcp = 1'b0, is_udp = 1'b0;
    logic [15:0]  ip_csum = '0, l4_csum = '0, ip_ident = '0;
    logic [2:0]   cfg_desc_type = '0;
    logic         cfg_ip_chk = 1'b0, cfg_l4_chk = 1'b0, cfg_no_ident = 1'b0;
    logic         cfg_strip_crc = 1'b0, cfg_long_pkt = 1'b0;
    logic [6:0]   cfg_buf_kb = '0;
    logic [15:0]  cfg_legacy_buf = 16'd2048;
    logic         out_valid, out_err_len, out_err_type;
    logic [127:0] out_desc;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           finished = 1'b0;

    always #5 clk = ~clk;

    rx_wb_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_len(frame_len),
        .is_ipv4(is_ipv4), .is_tcp(is_tcp), .is_udp(is_udp),
        .ip_csum(ip_csum), .l4_csum(l4_csum), .ip_ident(ip_ident),
        .cfg_desc_type(cfg_desc_type), .cfg_ip_chk(cfg_ip_chk), .cfg_l4_chk(cfg_l4_chk),
        .cfg_no_ident(cfg_no_ident), .cfg_strip_crc(cfg_strip_crc),
        .cfg_long_pkt(cfg_long_pkt), .cfg_buf_kb(cfg_buf_kb),
        .cfg_legacy_buf(cfg_legacy_buf), .out_valid(out_valid), .out_desc(out_desc),
        .out_err_len(out_err_len), .out_err_type(out_err_type)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected outcome from the requirement arithmetic, checked one cycle later
    task automatic run_one();
        logic onebuf, ok_type, ipc, l4c, fits;
        logic [16:0] bufsz;
        logic [15:0] exp_len, exp_cs;
        logic [7:0]  st, er;
        logic [11:0] pt, aer;
        onebuf  = (cfg_desc_type == 3'd1);
        ok_type = (cfg_desc_type == 3'd0) || onebuf;
        bufsz   = (onebuf && cfg_long_pkt) ? 17'(cfg_buf_kb) * 17'd1024 : 17'(cfg_legacy_buf);
        fits    = 17'(frame_len) < bufsz;
        ipc     = is_ipv4 && cfg_ip_chk;
        l4c     = is_ipv4 && cfg_l4_chk && (is_tcp || is_udp);
        exp_len = cfg_strip_crc ? frame_len : 16'(frame_len + 16'd4);
        exp_cs  = l4c ? l4_csum : (ipc ? ip_csum : 16'h0);
        st = 8'h03 | (ipc ? 8'h40 : 8'h0) | (l4c && is_tcp ? 8'h20 : 8'h0)
                   | (l4c && is_udp ? 8'h10 : 8'h0);
        er = ((ipc && ip_csum != 0) ? 8'h40 : 8'h0) | ((l4c && l4_csum != 0) ? 8'h20 : 8'h0);
        aer = ((ipc && ip_csum != 0) ? 12'h800 : 12'h0) | ((l4c && l4_csum != 0) ? 12'h400 : 12'h0);
        pt = (is_ipv4 ? 12'h001 : 12'h0) | (l4c && is_tcp ? 12'h010 : 12'h0)
           | (l4c && is_udp ? 12'h020 : 12'h0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "err_type", 128'(out_err_type), 128'(!ok_type));
        chk("R9", "err_len", 128'(out_err_len), 128'(ok_type && !fits));
        chk("R12", "valid", 128'(out_valid), 128'(ok_type && fits));
        if (ok_type && fits) begin
            chk("R10", "vlan", 128'(out_desc[127:112]), 128'h0);
            if (onebuf) begin
                chk("R6", "len", 128'(out_desc[111:96]), 128'(exp_len));
                chk("R2", "status", 128'(out_desc[83:64]), 128'(st));
                chk("R4", "errors", 128'(out_desc[95:84]), 128'(aer));
                chk("R5", "ptype", 128'(out_desc[15:4]), 128'(pt));
                chk("R8", "identword", 128'(out_desc[63:32]),
                    cfg_no_ident ? 128'h0 : 128'({exp_cs, ip_ident}));
                chk("R10", "zero", 128'({out_desc[31:16], out_desc[3:0]}), 128'h0);
            end else begin
                chk("R6", "len", 128'(out_desc[79:64]), 128'(exp_len));
                chk("R2", "status", 128'(out_desc[103:96]), 128'(st));
                chk("R3", "errors", 128'(out_desc[111:104]), 128'(er));
                chk("R7", "csum", 128'(out_desc[95:80]), 128'(exp_cs));
                chk("R10", "addr", 128'(out_desc[63:0]), 128'h0);
            end
        end else begin
            chk("R11", "desc on error", out_desc, 128'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset valid", 128'(out_valid), 128'h0);
        chk("R11", "reset desc", out_desc, 128'h0);
        chk("R11", "reset errs", 128'({out_err_len, out_err_type}), 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // main sweep
        for (int dt = 0; dt < 8; dt++) begin
            for (int cls = 0; cls < 4; cls++) begin
                for (int m = 0; m < 64; m++) begin
                    cfg_desc_type = 3'(dt);
                    is_ipv4 = (cls != 0);
                    is_tcp  = (cls == 2);
                    is_udp  = (cls == 3);
                    cfg_ip_chk    = m[0];
                    cfg_l4_chk    = m[1];
                    ip_csum       = m[2] ? 16'h1234 : 16'h0000;
                    l4_csum       = m[3] ? 16'hBEEF : 16'h0000;
                    cfg_strip_crc = m[4];
                    cfg_no_ident  = m[5];
                    ip_ident      = 16'(16'hA000 + m * 7 + cls);
                    frame_len     = 16'(60 + m * 13 + cls);
                    run_one();
                end
            end
        end
        // one-cycle pulse check
        chk("R11", "pulse ends", 128'(out_valid), 128'h0);
        // buffer boundaries, R9
        cfg_ip_chk = 1'b0; cfg_l4_chk = 1'b0; is_ipv4 = 1'b0;
        cfg_strip_crc = 1'b1;
        for (int dt = 0; dt < 2; dt++) begin
            for (int lp = 0; lp < 2; lp++) begin
                for (int kb = 0; kb < 4; kb++) begin
                    for (int d = -1; d < 2; d++) begin
                        cfg_desc_type = 3'(dt);
                        cfg_long_pkt  = lp[0];
                        cfg_buf_kb    = 7'(kb);
                        cfg_legacy_buf = 16'd1536;
                        frame_len = (dt == 1 && lp == 1) ? 16'(kb * 1024 + d)
                                                         : 16'(1536 + d);
                        if (frame_len == 16'hFFFF) frame_len = 16'd0;
                        run_one();
                    end
                end
            end
        end
        // large KB field and length wrap with CRC
        cfg_desc_type = 3'd1; cfg_long_pkt = 1'b1; cfg_buf_kb = 7'd127; cfg_strip_crc = 1'b0;
        frame_len = 16'hFFFE;
        run_one();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule